// File: doc/BRIEF.md
# Transmit Completion Mailbox Writer

This block turns each finished transmit packet into a 32-bit completion word and places it in one of two host-visible mailboxes. The packet engine pulses a completion strobe as soon as the last byte of a packet has been fetched from memory. It does not wait for the cells to reach the line. With the strobe it presents:
- an error flag,
- the channel (VC) number,
- whether the channel's next descriptor is valid,
- the low 15 bits of the descriptor's start address.

The block packs these fields into the completion word and pushes it into a small FIFO. It then sets that mailbox's status bit. A registered interrupt line is asserted while any status bit is set whose mask bit is clear.

Software drains a mailbox by selecting it, reading the head word and popping it. When the mailbox is empty, software clears the status bit with a write-one-to-clear. Writing the mask register silences a mailbox without losing its status. If a completion arrives at a full mailbox, that completion is discarded and a sticky overflow flag is raised. Software clears the flag explicitly.

Top module: `tx_done_mailbox`

## Requirements
- R1: The completion word has this layout:
  - bit 31 is the inverse of the error flag: 1 means no error, 0 means an error.
  - bits 30:16 are the 15-bit VC number.
  - bit 15 is 1 when the next descriptor is valid (channel stays active) and 0 when it is not (channel goes idle).
  - bits 14:0 are the descriptor address bits.
- R2: Bit 0 of the VC number selects the mailbox: 0 selects mailbox 0 and 1 selects mailbox 1. `hostSel` uses the same encoding to choose the mailbox that is read, popped and reported on `readValid`.
- R3: Each mailbox is a FIFO of DEPTH entries (default 8).
  - `readData` shows the oldest entry of the selected mailbox and changes only on a pop.
  - Words leave in arrival order.
  - `readValid` is 1 exactly when the selected mailbox holds at least one entry.
- R4: A completion strobe stores its word at the clock edge that samples it. The matching `statusBits` bit is 1 from that edge onward.
- R5: A completion aimed at a mailbox that already holds DEPTH entries is handled as follows:
  - the word is discarded and the stored entries are unchanged;
  - the mailbox's `overflowBits` bit becomes 1 and stays 1 until software writes 1 to the matching `hostClrOvf` bit.
- R6: A 1 on a `hostClrStatus` bit clears that status bit only when the mailbox will be empty after the same edge and no completion is stored into it at that edge. Otherwise the write is ignored.
- R7: `irq` is a register that, one edge later, reflects whether any mailbox has its status bit set and its mask bit clear.
- R8: A `hostMaskWr` pulse loads `hostMaskData` into the mask. Bit i at 1 masks mailbox i, and all mask bits are 0 after reset. Masking never changes a status bit.
- R9: Reset state:
  - both mailboxes are empty;
  - status, overflow and mask bits are 0;
  - `irq` is 0.
  A pop of an empty mailbox is ignored.
- R10: A completion and a pop hitting the same non-full mailbox on one edge both take effect, and the entry count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doneStrobe | input | 1 | One-cycle pulse: all data of a packet has been fetched |
| doneErr | input | 1 | 1 when the packet ended in error |
| doneVc | input | 15 | VC number of the packet; bit 0 picks the mailbox |
| doneNextValid | input | 1 | Next descriptor of this channel is valid |
| doneAddr | input | 15 | Low 15 bits of the descriptor start address |
| hostSel | input | 1 | Mailbox selected for read, pop and `readValid` |
| hostPop | input | 1 | Remove the head entry of the selected mailbox |
| readData | output | 32 | Head word of the selected mailbox |
| readValid | output | 1 | Selected mailbox is not empty |
| hostClrStatus | input | 2 | Write-one-to-clear of the status bits |
| hostClrOvf | input | 2 | Write-one-to-clear of the overflow bits |
| hostMaskWr | input | 1 | Load the mask register |
| hostMaskData | input | 2 | New mask value, 1 masks the mailbox |
| statusBits | output | 2 | Per-mailbox status bits |
| overflowBits | output | 2 | Per-mailbox sticky overflow flags |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the embedded assertions check the following:
- no FIFO is written when full or popped when empty;
- a stored word always leaves its status bit set;
- overflow flags stay set until they are cleared;
- a status bit cannot drop while its mailbox still holds more than one entry;
- `irq` tracks the unmasked status one edge late;
- a push coinciding with a pop leaves the count unchanged.

Only the bench scenarios can show that the packed word carries the right field in the right bit position, and that the VC parity routes it to the correct mailbox. They also show that words come out in arrival order, that the word dropped on overflow is the ninth and not an earlier one, and that a clear written to a non-empty mailbox really is ignored.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  // Number of completion mailboxes and field widths of the completion word.
  localparam int NUM_MBOX = 2;
  localparam int SEL_W    = $clog2(NUM_MBOX);
  localparam int VC_W     = 15;
  localparam int ADDR_W   = 15;
  localparam int WORD_W   = 1 + VC_W + 1 + ADDR_W;

  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic [NUM_MBOX-1:0] push;
    logic [NUM_MBOX-1:0] pop;
  } mbStrobe_t;

  // Pack a completion word: inverted error, VC, active flag, address.
  function automatic logic [WORD_W-1:0] packWord(
    input logic              err,
    input logic [VC_W-1:0]   vc,
    input logic              nextValid,
    input logic [ADDR_W-1:0] addr
  );
    return {~err, vc, nextValid, addr};
  endfunction
endpackage

// File: rtl/txmb_datapath.sv
module txmb_datapath
  import txmb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  mbStrobe_t                       strobe,
  input  logic                            inErr,
  input  logic [VC_W-1:0]                 inVc,
  input  logic                            inNextValid,
  input  logic [ADDR_W-1:0]               inAddr,
  input  logic [SEL_W-1:0]                hostSel,
  output logic [NUM_MBOX-1:0][CNT_W-1:0]  count,
  output logic [WORD_W-1:0]               readData,
  output logic                            readValid
);
  logic [WORD_W-1:0] newWord;
  logic [NUM_MBOX-1:0][WORD_W-1:0] headWord;

  assign newWord = packWord(inErr, inVc, inNextValid, inAddr);

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
    logic [WORD_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (strobe.push[m]) begin
          store[wrPtr] <= newWord;
          wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        end
        if (strobe.pop[m]) begin
          rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        end
        case ({strobe.push[m], strobe.pop[m]})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign headWord[m] = store[rdPtr];
    assign count[m]    = cnt;

    // R5: the control must never push into a full FIFO
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
      strobe.push[m] |-> (cnt < CNT_W'(DEPTH)))
      else $error("push into full mailbox %0d", m);

    // R9: no pop from an empty FIFO
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
      strobe.pop[m] |-> (cnt != '0))
      else $error("pop from empty mailbox %0d", m);

    // R10: simultaneous push and pop keep the occupancy
    p_count_steady_r10: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.push[m] && strobe.pop[m]) |=> $stable(cnt))
      else $error("count moved on push+pop, mailbox %0d", m);
  end

  assign readData  = headWord[hostSel];
  assign readValid = (count[hostSel] != '0);
endmodule

// File: rtl/txmb_control.sv
module txmb_control
  import txmb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            doneStrobe,
  input  logic [SEL_W-1:0]                doneSel,
  input  logic [SEL_W-1:0]                hostSel,
  input  logic                            hostPop,
  input  logic [NUM_MBOX-1:0]             hostClrStatus,
  input  logic [NUM_MBOX-1:0]             hostClrOvf,
  input  logic                            hostMaskWr,
  input  logic [NUM_MBOX-1:0]             hostMaskData,
  input  logic [NUM_MBOX-1:0][CNT_W-1:0]  count,
  output mbStrobe_t                       strobe,
  output logic [NUM_MBOX-1:0]             statusBits,
  output logic [NUM_MBOX-1:0]             overflowBits,
  output logic                            irq
);
  logic [NUM_MBOX-1:0] maskBits;
  logic [NUM_MBOX-1:0] dropHit;

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_ctl
    logic isFull;
    logic isEmpty;
    logic aimed;
    logic emptyAfter;

    assign isFull     = (count[m] == CNT_W'(DEPTH));
    assign isEmpty    = (count[m] == '0);
    assign aimed      = doneStrobe && (doneSel == SEL_W'(m));
    assign strobe.push[m] = aimed && !isFull;
    assign dropHit[m]     = aimed && isFull;
    assign strobe.pop[m]  = hostPop && (hostSel == SEL_W'(m)) && !isEmpty;
    assign emptyAfter = isEmpty || ((count[m] == CNT_W'(1)) && strobe.pop[m]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusBits[m]   <= 1'b0;
        overflowBits[m] <= 1'b0;
      end else begin
        if (strobe.push[m])
          statusBits[m] <= 1'b1;
        else if (hostClrStatus[m] && emptyAfter)
          statusBits[m] <= 1'b0;

        if (dropHit[m])
          overflowBits[m] <= 1'b1;
        else if (hostClrOvf[m])
          overflowBits[m] <= 1'b0;
      end
    end

    // R4: a stored word always leaves its status bit set
    p_status_set_r4: assert property (@(posedge clk) disable iff (!rstN)
      strobe.push[m] |=> statusBits[m])
      else $error("status not set after store, mailbox %0d", m);

    // R6: status cannot drop while entries would remain
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (statusBits[m] && count[m] > CNT_W'(1)) |=> statusBits[m])
      else $error("status cleared on non-empty mailbox %0d", m);

    // R5: overflow flag is sticky until its clear
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
      (overflowBits[m] && !hostClrOvf[m]) |=> overflowBits[m])
      else $error("overflow flag lost, mailbox %0d", m);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskBits <= '0;
      irq      <= 1'b0;
    end else begin
      if (hostMaskWr) maskBits <= hostMaskData;
      irq <= |(statusBits & ~maskBits);
    end
  end

  // R7: irq follows unmasked status one edge later
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusBits & ~maskBits)) |=> irq)
    else $error("irq missing");
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusBits & ~maskBits)) |=> !irq)
    else $error("irq spurious");
endmodule

// File: rtl/tx_done_mailbox.sv
module tx_done_mailbox
  import txmb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 doneStrobe,
  input  logic                 doneErr,
  input  logic [VC_W-1:0]      doneVc,
  input  logic                 doneNextValid,
  input  logic [ADDR_W-1:0]    doneAddr,
  input  logic [SEL_W-1:0]     hostSel,
  input  logic                 hostPop,
  output logic [WORD_W-1:0]    readData,
  output logic                 readValid,
  input  logic [NUM_MBOX-1:0]  hostClrStatus,
  input  logic [NUM_MBOX-1:0]  hostClrOvf,
  input  logic                 hostMaskWr,
  input  logic [NUM_MBOX-1:0]  hostMaskData,
  output logic [NUM_MBOX-1:0]  statusBits,
  output logic [NUM_MBOX-1:0]  overflowBits,
  output logic                 irq
);
  mbStrobe_t strobe;
  logic [NUM_MBOX-1:0][CNT_W-1:0] count;

  txmb_control #(.DEPTH(DEPTH)) u_control (
    .clk(clk), .rstN(rstN),
    .doneStrobe(doneStrobe), .doneSel(doneVc[SEL_W-1:0]),
    .hostSel(hostSel), .hostPop(hostPop),
    .hostClrStatus(hostClrStatus), .hostClrOvf(hostClrOvf),
    .hostMaskWr(hostMaskWr), .hostMaskData(hostMaskData),
    .count(count), .strobe(strobe),
    .statusBits(statusBits), .overflowBits(overflowBits), .irq(irq)
  );

  txmb_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inErr(doneErr), .inVc(doneVc), .inNextValid(doneNextValid),
    .inAddr(doneAddr), .hostSel(hostSel),
    .count(count), .readData(readData), .readValid(readValid)
  );
endmodule

// File: tb/tx_done_mailbox_bench.sv
module tx_done_mailbox_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        doneStrobe = 1'b0;
  logic        doneErr = 1'b0;
  logic [14:0] doneVc = '0;
  logic        doneNextValid = 1'b0;
  logic [14:0] doneAddr = '0;
  logic        hostSel = 1'b0;
  logic        hostPop = 1'b0;
  logic [31:0] readData;
  logic        readValid;
  logic [1:0]  hostClrStatus = '0;
  logic [1:0]  hostClrOvf = '0;
  logic        hostMaskWr = 1'b0;
  logic [1:0]  hostMaskData = '0;
  logic [1:0]  statusBits;
  logic [1:0]  overflowBits;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tx_done_mailbox u_tx_done_mailbox (
    .clk(clk), .rstN(rstN), .doneStrobe(doneStrobe), .doneErr(doneErr),
    .doneVc(doneVc), .doneNextValid(doneNextValid), .doneAddr(doneAddr),
    .hostSel(hostSel), .hostPop(hostPop), .readData(readData),
    .readValid(readValid), .hostClrStatus(hostClrStatus),
    .hostClrOvf(hostClrOvf), .hostMaskWr(hostMaskWr),
    .hostMaskData(hostMaskData), .statusBits(statusBits),
    .overflowBits(overflowBits), .irq(irq)
  );

  typedef struct packed {
    logic        mbox;
    logic [31:0] word;
    logic        err;
    logic [14:0] vc;
    logic        nv;
    logic [14:0] addr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h8004A345, 1'b0, 15'h0004, 1'b1, 15'h2345},
    '{1'b1, 32'h7FFF7FFF, 1'b1, 15'h7FFF, 1'b0, 15'h7FFF},
    '{1'b0, 32'h80020001, 1'b0, 15'h0002, 1'b0, 15'h0001},
    '{1'b1, 32'h0003C000, 1'b1, 15'h0003, 1'b1, 15'h4000},
    '{1'b0, 32'hD554FFFF, 1'b0, 15'h5554, 1'b1, 15'h7FFF},
    '{1'b1, 32'h00010000, 1'b1, 15'h0001, 1'b0, 15'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pushInd(input logic e, input logic [14:0] vc, input logic nv, input logic [14:0] a);
    @(negedge clk);
    doneStrobe = 1'b1; doneErr = e; doneVc = vc; doneNextValid = nv; doneAddr = a;
    @(negedge clk);
    doneStrobe = 1'b0;
  endtask

  task automatic popOne(input logic sel);
    @(negedge clk);
    hostSel = sel; hostPop = 1'b1;
    @(negedge clk);
    hostPop = 1'b0;
  endtask

  task automatic clrStatus(input logic [1:0] bits);
    @(negedge clk);
    hostClrStatus = bits;
    @(negedge clk);
    hostClrStatus = '0;
  endtask

  task automatic look(input logic sel);
    hostSel = sel;
    #0.5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 status", 32'(statusBits), 32'h0);
    chk("R9 overflow", 32'(overflowBits), 32'h0);
    chk("R9 irq", 32'(irq), 32'h0);
    look(1'b0); chk("R9 mbox0 empty", 32'(readValid), 32'h0);
    look(1'b1); chk("R9 mbox1 empty", 32'(readValid), 32'h0);

    // Table walk: R1 format, R2 routing, R4 status, R6 clear on empty
    for (int i = 0; i < NV; i++) begin
      pushInd(VEC[i].err, VEC[i].vc, VEC[i].nv, VEC[i].addr);
      chk("R4 status set", 32'(statusBits[VEC[i].mbox]), 32'h1);
      look(~VEC[i].mbox);
      chk("R2 other mailbox empty", 32'(readValid), 32'h0);
      look(VEC[i].mbox);
      chk("R2 routed mailbox valid", 32'(readValid), 32'h1);
      chk("R1 word", readData, VEC[i].word);
      popOne(VEC[i].mbox);
      clrStatus(2'b11);
      chk("R6 clear when empty", 32'(statusBits), 32'h0);
    end
    @(negedge clk);

    // R3 + R5: fill mailbox 0 beyond depth
    for (int i = 0; i < 9; i++) pushInd(1'b0, 15'h0000, 1'b0, 15'(i + 1));
    chk("R5 overflow set", 32'(overflowBits), 32'h1);
    look(1'b0);
    for (int i = 0; i < 8; i++) begin
      chk("R3 fifo order", readData, 32'h80000000 | 32'(i + 1));
      chk("R3 valid while filled", 32'(readValid), 32'h1);
      popOne(1'b0);
    end
    chk("R5 ninth dropped", 32'(readValid), 32'h0);
    chk("R5 overflow sticky", 32'(overflowBits), 32'h1);
    @(negedge clk); hostClrOvf = 2'b01; @(negedge clk); hostClrOvf = '0;
    chk("R5 overflow cleared", 32'(overflowBits), 32'h0);
    clrStatus(2'b01);

    // R6: clear ignored while entries remain
    pushInd(1'b0, 15'h0010, 1'b1, 15'h0007);
    clrStatus(2'b01);
    chk("R6 clear ignored non-empty", 32'(statusBits), 32'h1);
    popOne(1'b0);
    chk("R6 still set after pop", 32'(statusBits), 32'h1);
    clrStatus(2'b01);
    chk("R6 clear after drain", 32'(statusBits), 32'h0);
    @(negedge clk);
    chk("R7 irq low when clear", 32'(irq), 32'h0);

    // R7 + R8: interrupt timing and masking
    pushInd(1'b0, 15'h0020, 1'b0, 15'h0001);
    chk("R7 irq one edge late", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R7 irq raised", 32'(irq), 32'h1);
    @(negedge clk); hostMaskWr = 1'b1; hostMaskData = 2'b01;
    @(negedge clk); hostMaskWr = 1'b0;
    chk("R7 irq lags mask", 32'(irq), 32'h1);
    @(negedge clk);
    chk("R8 masked irq low", 32'(irq), 32'h0);
    chk("R8 mask keeps status", 32'(statusBits), 32'h1);
    pushInd(1'b1, 15'h0021, 1'b1, 15'h0002);
    @(negedge clk);
    chk("R8 unmasked mailbox raises irq", 32'(irq), 32'h1);
    popOne(1'b1); clrStatus(2'b10);
    @(negedge clk);
    chk("R8 only masked status left", 32'(irq), 32'h0);
    @(negedge clk); hostMaskWr = 1'b1; hostMaskData = 2'b00;
    @(negedge clk); hostMaskWr = 1'b0;
    @(negedge clk);
    chk("R8 unmask raises irq", 32'(irq), 32'h1);
    popOne(1'b0); clrStatus(2'b01);

    // R9: pop on empty is ignored
    popOne(1'b1);
    pushInd(1'b0, 15'h0031, 1'b1, 15'h0033);
    look(1'b1);
    chk("R9 word after empty pop", readData, 32'h80318033);
    popOne(1'b1);
    chk("R9 single entry gone", 32'(readValid), 32'h0);
    clrStatus(2'b10);

    // R10: push and pop on one edge
    pushInd(1'b0, 15'h0040, 1'b0, 15'h0011);
    @(negedge clk);
    hostSel = 1'b0; hostPop = 1'b1;
    doneStrobe = 1'b1; doneErr = 1'b1; doneVc = 15'h0042; doneNextValid = 1'b1; doneAddr = 15'h0022;
    @(negedge clk);
    hostPop = 1'b0; doneStrobe = 1'b0;
    look(1'b0);
    chk("R10 new head", readData, 32'h00428022);
    chk("R10 still one entry", 32'(readValid), 32'h1);
    popOne(1'b0);
    chk("R10 drained", 32'(readValid), 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule